// File: doc/BRIEF.md
# Receive Buffer Status and Interrupt Flags

This block keeps the completion and overrun flags for a bank of receive message buffers and derives the controller interrupt from them. When the storage logic writes a message into a buffer, it pulses that buffer's stored input for one clock cycle. The block then raises the buffer's "received" flag. If the same buffer is written again before software has acknowledged the earlier message, the block also raises the buffer's "overrun" flag.

Software acknowledges messages in one of two ways. A per-buffer clear wipes both flags of one buffer. A global clear wipes the flags of every buffer. Two further status bits record that a transmission completed and that a reception landed in any buffer. The interrupt line is high while either of these bits is set. A separate interrupt clear drops both bits, and with them the interrupt line.

All outputs are registered. They change on the clock edge after the edge at which the stimulus is sampled. Reset is synchronous and active high.

Top module: `rxs_status_top`

## Requirements
- R1: While `rst` is high, every `rx_ok`, `rx_ovr`, `sync_tx`, `sync_rx` and `irq` output is 0 after the next clock edge.
- R2: A pulse on `rx_stored[n]` sets `rx_ok[n]` at the following edge.
- R3: A pulse on `rx_stored[n]` while `rx_ok[n]` is 1, with no clear to buffer n in that cycle, sets `rx_ovr[n]`. `rx_ovr[n]` then stays 1 until buffer n is cleared, and it is never 1 while `rx_ok[n]` is 0.
- R4: A pulse on `rx_stored[n]` while `rx_ok[n]` is 0 leaves `rx_ovr[n]` at 0.
- R5: `rx_clr_buf[n]` without a reception into buffer n clears `rx_ok[n]` and `rx_ovr[n]`. The flags of the other buffers are unchanged.
- R6: `rx_clr_all` without receptions clears `rx_ok` and `rx_ovr` of every buffer.
- R7: If a reception into buffer n and a clear of buffer n (per-buffer or global) occur in the same cycle, the result is `rx_ok[n]`=1 and `rx_ovr[n]`=0.
- R8: `tx_done` sets `sync_tx`. A pulse on any bit of `rx_stored` sets `sync_rx`.
- R9: `irq` equals `sync_tx` OR `sync_rx`.
- R10: `irq_clr` clears `sync_tx` and `sync_rx`. If a setting event for a bit arrives in the same cycle, that bit is set instead of cleared.
- R11: `irq_clr` has no effect on `rx_ok` or `rx_ovr`. The receive clears have no effect on `sync_tx`, `sync_rx` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stored | input | NUM_BUF | One-cycle pulse per buffer: a message was written into it |
| tx_done | input | 1 | One-cycle pulse: a transmission completed |
| rx_clr_all | input | 1 | Clear the flags of every buffer |
| rx_clr_buf | input | NUM_BUF | Clear the flags of the selected buffers |
| irq_clr | input | 1 | Clear both event bits and the interrupt |
| rx_ok | output | NUM_BUF | Per-buffer received flag |
| rx_ovr | output | NUM_BUF | Per-buffer overrun flag |
| sync_tx | output | 1 | Transmit-complete event bit |
| sync_rx | output | 1 | Receive event bit |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets receptions that coincide with a per-buffer or global clear. A design that gives the clear priority would lose a freshly stored message; one that keeps the old overrun would report a false overrun. It also writes one buffer back to back, to catch overrun logic that compares against the wrong buffer. It clears one buffer and checks that its neighbours keep their flags, which exposes a design that decodes the per-buffer clears wrongly. Finally, it pulses `irq_clr` together with `tx_done` or a reception and checks that the interrupt survives; a design that drops it would lose an event.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Flags of one receive buffer
  typedef struct packed {
    logic ok;
    logic ovr;
  } buf_flags_t;

  // Next flag state for one buffer, given a store pulse and a clear
  function automatic buf_flags_t next_flags(buf_flags_t cur, logic store, logic clr);
    buf_flags_t n;
    n = cur;
    if (store) begin
      n.ok  = 1'b1;
      n.ovr = clr ? 1'b0 : (cur.ovr | cur.ok);
    end else if (clr) begin
      n.ok  = 1'b0;
      n.ovr = 1'b0;
    end
    return n;
  endfunction

  // Next state of an event bit: a set beats a clear
  function automatic logic next_event(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rxs_buf_flags.sv
module rxs_buf_flags
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic store,
  input  logic clr,
  output logic ok,
  output logic ovr
);
  buf_flags_t cur_q, nxt;
  logic overrun_ev;

  assign nxt        = next_flags(cur_q, store, clr);
  assign overrun_ev = store & cur_q.ok & ~clr;

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= nxt;
  end

  assign ok  = cur_q.ok;
  assign ovr = cur_q.ovr;

  // R2
  store_sets_ok_chk: assert property (@(posedge clk) disable iff (rst)
    store |=> ok);
  // R3
  overrun_raise_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_ev |=> ovr);
  // R3
  ovr_implies_ok_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |-> ok);
  // R4
  first_store_no_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (store && !ok && !ovr) |=> !ovr);
  // R5
  clear_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !store) |=> (!ok && !ovr));
  // R7
  store_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && store) |=> (ok && !ovr));
endmodule

// File: rtl/rxs_sync_irq.sv
module rxs_sync_irq
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_ev,
  input  logic rx_ev,
  input  logic irq_clr,
  output logic sync_tx,
  output logic sync_rx,
  output logic irq
);
  logic tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= next_event(tx_q, tx_ev, irq_clr);
      rx_q <= next_event(rx_q, rx_ev, irq_clr);
    end
  end

  assign sync_tx = tx_q;
  assign sync_rx = rx_q;
  assign irq     = tx_q | rx_q;

  // R8
  tx_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ev |=> (sync_tx && irq));
  // R8
  rx_sets_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ev |=> (sync_rx && irq));
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !tx_ev && !rx_ev) |=> !irq);
  // R11
  events_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_clr && !tx_ev && !rx_ev) |=> ($stable(sync_tx) && $stable(sync_rx)));
endmodule

// File: rtl/rxs_status_top.sv
module rxs_status_top #(
  parameter int NUM_BUF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] rx_stored,
  input  logic               tx_done,
  input  logic               rx_clr_all,
  input  logic [NUM_BUF-1:0] rx_clr_buf,
  input  logic               irq_clr,
  output logic [NUM_BUF-1:0] rx_ok,
  output logic [NUM_BUF-1:0] rx_ovr,
  output logic               sync_tx,
  output logic               sync_rx,
  output logic               irq
);
  logic [NUM_BUF-1:0] buf_clr;
  logic               any_rx;

  assign buf_clr = rx_clr_buf | {NUM_BUF{rx_clr_all}};
  assign any_rx  = |rx_stored;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    rxs_buf_flags u_flags (
      .clk  (clk),
      .rst  (rst),
      .store(rx_stored[g]),
      .clr  (buf_clr[g]),
      .ok   (rx_ok[g]),
      .ovr  (rx_ovr[g])
    );
  end

  rxs_sync_irq u_sync (
    .clk    (clk),
    .rst    (rst),
    .tx_ev  (tx_done),
    .rx_ev  (any_rx),
    .irq_clr(irq_clr),
    .sync_tx(sync_tx),
    .sync_rx(sync_rx),
    .irq    (irq)
  );

  // R6
  global_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_clr_all && rx_stored == '0) |=> (rx_ok == '0 && rx_ovr == '0));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rx_ok == '0 && rx_ovr == '0 && !irq));
endmodule

// File: tb/test_rxs_status_top.sv
module test_rxs_status_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] rx_stored, rx_clr_buf, rx_ok, rx_ovr;
  logic tx_done, rx_clr_all, irq_clr, sync_tx, sync_rx, irq;

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [N-1:0] m_ok, m_ovr;
  logic m_tx, m_rx;

  always #10 clk = ~clk;  // 50 MHz

  rxs_status_top #(.NUM_BUF(N)) i_rxs_status_top (
    .clk(clk), .rst(rst), .rx_stored(rx_stored), .tx_done(tx_done),
    .rx_clr_all(rx_clr_all), .rx_clr_buf(rx_clr_buf), .irq_clr(irq_clr),
    .rx_ok(rx_ok), .rx_ovr(rx_ovr), .sync_tx(sync_tx), .sync_rx(sync_rx), .irq(irq)
  );

  // Expected flags, written from the requirements (R2 R3 R4 R5 R6 R7)
  function automatic logic [N-1:0] exp_ok(logic [N-1:0] ok, logic [N-1:0] st, logic [N-1:0] clr);
    return st | (ok & ~clr);
  endfunction
  function automatic logic [N-1:0] exp_ovr(logic [N-1:0] ok, logic [N-1:0] ovr,
                                           logic [N-1:0] st, logic [N-1:0] clr);
    return (st & ok & ~clr & ~ovr) | (ovr & ~clr);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model, sample 5 ns after the rising edge
  task automatic step(logic [N-1:0] st, logic txd, logic ca, logic [N-1:0] cb, logic ic);
    logic [N-1:0] clr;
    @(negedge clk);
    rx_stored = st; tx_done = txd; rx_clr_all = ca; rx_clr_buf = cb; irq_clr = ic;
    @(posedge clk);
    clr   = cb | {N{ca}};
    m_ovr = exp_ovr(m_ok, m_ovr, st, clr);
    m_ok  = exp_ok(m_ok, st, clr);
    m_tx  = txd | (m_tx & ~ic);        // R8 R10
    m_rx  = (|st) | (m_rx & ~ic);
    #5;
    check("R2 rx_ok", 32'(rx_ok), 32'(m_ok));
    check("R3 rx_ovr", 32'(rx_ovr), 32'(m_ovr));
    check("R8 sync_tx", 32'(sync_tx), 32'(m_tx));
    check("R8 sync_rx", 32'(sync_rx), 32'(m_rx));
    check("R9 irq", 32'(irq), 32'(m_tx | m_rx));
  endtask

  initial begin
    rst = 1'b1; rx_stored = '0; tx_done = 0; rx_clr_all = 0; rx_clr_buf = '0; irq_clr = 0;
    m_ok = '0; m_ovr = '0; m_tx = 0; m_rx = 0;
    repeat (3) @(posedge clk);
    #5;
    // R1
    check("R1 reset flags", 32'({rx_ok, rx_ovr}), 32'h0);
    check("R1 reset irq", 32'({sync_tx, sync_rx, irq}), 32'h0);
    @(negedge clk); rst = 1'b0;

    // R2 R4: first store into buffer 0
    step(4'b0001, 0, 0, 4'b0000, 0);
    check("R2 ok0 set", 32'(rx_ok[0]), 32'h1);
    check("R4 no ovr on first store", 32'(rx_ovr[0]), 32'h0);
    // R3: second store before clear
    step(4'b0001, 0, 0, 4'b0000, 0);
    check("R3 overrun buf0", 32'(rx_ovr[0]), 32'h1);
    step(4'b0000, 0, 0, 4'b0000, 0);
    check("R3 overrun sticky", 32'(rx_ovr[0]), 32'h1);
    // R5: per-buffer clear of buffer 1 spares 0 and 2
    step(4'b0110, 0, 0, 4'b0000, 0);
    step(4'b0000, 0, 0, 4'b0010, 0);
    check("R5 per-buffer clear", 32'(rx_ok), 32'h5);
    check("R5 others keep ovr", 32'(rx_ovr), 32'h1);
    // R7: store and clear together on buffer 2 (ok already set)
    step(4'b0100, 0, 0, 4'b0100, 0);
    check("R7 store beats clear ok", 32'(rx_ok[2]), 32'h1);
    check("R7 store beats clear ovr", 32'(rx_ovr[2]), 32'h0);
    // R7 with global clear on buffer 0 (overrun set)
    step(4'b0001, 0, 1, 4'b0000, 0);
    check("R7 global clear vs store", 32'({rx_ok, rx_ovr}), 32'h10);
    // R6 + R11: global clear leaves event bits
    step(4'b0000, 0, 1, 4'b0000, 0);
    check("R6 global clear", 32'({rx_ok, rx_ovr}), 32'h0);
    check("R11 sync_rx kept by rx clear", 32'(sync_rx), 32'h1);
    // R8 R9 transmit
    step(4'b0000, 1, 0, 4'b0000, 0);
    check("R8 sync_tx set", 32'(sync_tx), 32'h1);
    check("R9 irq high", 32'(irq), 32'h1);
    // R10 R11: interrupt clear leaves buffer flags
    step(4'b1000, 0, 0, 4'b0000, 0);
    step(4'b0000, 0, 0, 4'b0000, 1);
    check("R10 irq cleared", 32'({sync_tx, sync_rx, irq}), 32'h0);
    check("R11 flags kept by irq_clr", 32'(rx_ok), 32'h8);
    // R10: set beats clear
    step(4'b0000, 1, 0, 4'b0000, 1);
    check("R10 tx beats irq_clr", 32'({sync_tx, sync_rx, irq}), 32'h5);
    step(4'b0010, 0, 0, 4'b0000, 1);
    check("R10 rx beats irq_clr", 32'({sync_tx, sync_rx, irq}), 32'h3);

    // Constrained random phase against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] st, cb;
      for (int b = 0; b < N; b++) begin
        st[b] = ($urandom % 4) == 0;
        cb[b] = ($urandom % 6) == 0;
      end
      step(st, ($urandom % 8) == 0, ($urandom % 16) == 0, cb, ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule